// File: doc/BRIEF.md
# Reconfigurable Bidirectional Pixel Line Shifter

This block gathers one display line of 96 binary pixel values from a narrow parallel bus. Every stage of a single 96-bit register is an output position. A layout input splits that register into lanes. With the input low there are six lanes of sixteen stages, one per data input. With it high there are three lanes of thirty-two stages, and only the three lowest data inputs are used. A direction input picks whether fresh samples enter at the low end of the register and climb, or enter at the high end and descend. Consecutive lanes fill neighbouring output positions, so the six or three inputs of one sample form a group that moves as a unit.

Samples are taken on a rising clock edge while the shift enable is high. A downstream latch reads the full 96-bit contents in parallel. A fill counter raises a flag once a complete line has been shifted in: that takes 16 shifts in the six-lane layout and 32 in the three-lane layout. The mode and direction inputs may only change between complete line loads.

Top module: `pdp_line_shifter`

## Requirements
- R1: A rising clock edge with the synchronous active-low reset low clears all 96 stages and the full flag to zero.
- R2: On a rising edge with the shift enable low, all 96 stages and the full flag keep their values, whatever the data inputs carry.
- R3: Six-lane upward mode (layout 0, direction 0): a shift puts data bit j (j = 0..5) into stage j, and stage i moves to stage i+6.
- R4: Six-lane downward mode (layout 0, direction 1): a shift puts data bit j into stage 90+j, and stage i moves to stage i-6.
- R5: Three-lane upward mode (layout 1, direction 0): a shift puts data bit j (j = 0..2) into stage j, and stage i moves to stage i+3.
- R6: Three-lane downward mode (layout 1, direction 1): a shift puts data bit j into stage 93+j, and stage i moves to stage i-3.
- R7: In the three-lane layout, data bits 3 to 5 have no effect on any stage.
- R8: After a complete line load (16 or 32 shifts) in upward mode, the sample of shift s on input j sits at stage S*(D-s)+j. In downward mode it sits at stage 96-S*(D-s+1)+j. Here S is the lane count and D is the depth.
- R9: The full flag rises on the shift that completes the line: the 16th shift in the six-lane layout, the 32nd in the three-lane layout. It clears on the next shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | Sample and shift on this edge |
| narrow_mode | input | 1 | 0: six lanes of 16, 1: three lanes of 32 |
| reverse | input | 1 | 0: enter low and climb, 1: enter high and descend |
| din | input | 6 | Lane data inputs; bit j feeds lane j |
| line_q | output | 96 | Register contents; bit i is output position i+1 |
| line_full | output | 1 | A complete line has just been loaded |

## Verification
Every result in this block is due one register stage after its stimulus. A shift, an idle edge or a reset edge changes `line_q` and `line_full` on that same rising edge. The bench drives inputs at the falling edge and samples one time unit after the rising edge that follows. After every edge it compares all 96 stages with a position formula worked out from the number of shifts so far and the recorded samples. The flag is compared with the shift count on the same edge. Idle edges are inserted in the middle of loads, and the loads run one shift past full, so the hold rule and the clearing of the flag are checked on the edge where each applies.

// File: rtl/pdp_shift_pkg.sv
package pdp_shift_pkg;
   typedef enum logic {
      LAYOUT_WIDE   = 1'b0,
      LAYOUT_NARROW = 1'b1
   } layout_e;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } dir_e;
endpackage

// File: rtl/pdp_lane_array.sv
module pdp_lane_array
   import pdp_shift_pkg::*;
#(
   parameter int unsigned LANES = 6,
   parameter int unsigned DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift_en,
   input  layout_e                  layout,
   input  dir_e                     dir,
   input  logic [LANES-1:0]         din,
   output logic [LANES*DEPTH-1:0]   q
);
   localparam int unsigned WIDTH  = LANES * DEPTH;
   localparam int unsigned NLANES = LANES / 2;

   logic [WIDTH-1:0] nxt;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic up_w, up_n, dn_w, dn_n;

      if (i < LANES) begin : g_up_w_in
         assign up_w = din[i];
      end else begin : g_up_w_sh
         assign up_w = q[i-LANES];
      end

      if (i < NLANES) begin : g_up_n_in
         assign up_n = din[i];
      end else begin : g_up_n_sh
         assign up_n = q[i-NLANES];
      end

      if (i >= WIDTH - LANES) begin : g_dn_w_in
         assign dn_w = din[i-(WIDTH-LANES)];
      end else begin : g_dn_w_sh
         assign dn_w = q[i+LANES];
      end

      if (i >= WIDTH - NLANES) begin : g_dn_n_in
         assign dn_n = din[i-(WIDTH-NLANES)];
      end else begin : g_dn_n_sh
         assign dn_n = q[i+NLANES];
      end

      always_comb begin
         unique case ({layout, dir})
            {LAYOUT_WIDE,   DIR_UP}   : nxt[i] = up_w;
            {LAYOUT_WIDE,   DIR_DOWN} : nxt[i] = dn_w;
            {LAYOUT_NARROW, DIR_UP}   : nxt[i] = up_n;
            default                   : nxt[i] = dn_n;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (shift_en) begin
         q <= nxt;
      end
   end
endmodule

// File: rtl/pdp_fill_counter.sv
module pdp_fill_counter
   import pdp_shift_pkg::*;
#(
   parameter int unsigned DEPTH_WIDE   = 16,
   parameter int unsigned DEPTH_NARROW = 32
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    shift_en,
   input  layout_e layout,
   output logic    full
);
   localparam int unsigned CW = $clog2(DEPTH_NARROW + 1);
   localparam logic [CW-1:0] LAST_WIDE   = CW'(DEPTH_WIDE - 1);
   localparam logic [CW-1:0] LAST_NARROW = CW'(DEPTH_NARROW - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = (layout == LAYOUT_NARROW) ? LAST_NARROW : LAST_WIDE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         full <= 1'b0;
      end else if (shift_en) begin
         if (cnt == last) begin
            cnt  <= '0;
            full <= 1'b1;
         end else begin
            cnt  <= cnt + 1'b1;
            full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pdp_line_shifter.sv
module pdp_line_shifter
   import pdp_shift_pkg::*;
#(
   parameter int unsigned LANES = 6,
   parameter int unsigned DEPTH = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   shift_en,
   input  logic                   narrow_mode,
   input  logic                   reverse,
   input  logic [LANES-1:0]       din,
   output logic [LANES*DEPTH-1:0] line_q,
   output logic                   line_full
);
   localparam int unsigned NARROW_DEPTH = DEPTH * 2;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("LANES must be even and at least 2");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end

   layout_e layout;
   dir_e    dir;

   assign layout = layout_e'(narrow_mode);
   assign dir    = dir_e'(reverse);

   pdp_lane_array #(
      .LANES (LANES),
      .DEPTH (DEPTH)
   ) i_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .layout   (layout),
      .dir      (dir),
      .din      (din),
      .q        (line_q)
   );

   pdp_fill_counter #(
      .DEPTH_WIDE   (DEPTH),
      .DEPTH_NARROW (NARROW_DEPTH)
   ) i_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .layout   (layout),
      .full     (line_full)
   );
endmodule

// File: rtl/pdp_line_shifter_chk.sv
module pdp_line_shifter_chk #(
   parameter int unsigned LANES = 6,
   parameter int unsigned DEPTH = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   shift_en,
   input logic                   narrow_mode,
   input logic                   reverse,
   input logic [LANES-1:0]       din,
   input logic [LANES*DEPTH-1:0] line_q,
   input logic                   line_full
);
   localparam int unsigned W = LANES * DEPTH;
   localparam int unsigned H = LANES / 2;

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> ($stable(line_q) && $stable(line_full))); // R2

   AST_WIDE_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !narrow_mode && !reverse) |=>
         (line_q[LANES-1:0] == $past(din) &&
          line_q[W-1:LANES] == $past(line_q[W-LANES-1:0]))); // R3

   AST_WIDE_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !narrow_mode && reverse) |=>
         (line_q[W-1:W-LANES] == $past(din) &&
          line_q[W-LANES-1:0] == $past(line_q[W-1:LANES]))); // R4

   AST_NARROW_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && narrow_mode && !reverse) |=>
         (line_q[H-1:0] == $past(din[H-1:0]) &&
          line_q[W-1:H] == $past(line_q[W-H-1:0]))); // R5

   AST_NARROW_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && narrow_mode && reverse) |=>
         (line_q[W-1:W-H] == $past(din[H-1:0]) &&
          line_q[W-H-1:0] == $past(line_q[W-1:H]))); // R6

   AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (line_full && shift_en) |=> !line_full); // R9
endmodule

bind pdp_line_shifter pdp_line_shifter_chk #(
   .LANES (LANES),
   .DEPTH (DEPTH)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .shift_en    (shift_en),
   .narrow_mode (narrow_mode),
   .reverse     (reverse),
   .din         (din),
   .line_q      (line_q),
   .line_full   (line_full)
);

// File: tb/test_pdp_line_shifter.sv
module test_pdp_line_shifter;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 6;
   localparam int DEPTH = 16;
   localparam int W = LANES * DEPTH;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           shift_en = 1'b0;
   logic           narrow_mode = 1'b0;
   logic           reverse = 1'b0;
   logic [LANES-1:0] din = '0;
   logic [W-1:0]   line_q;
   logic           line_full;

   int vectors = 0;
   int miscompares = 0;
   logic [LANES-1:0] hist [1:40];

   always #(CLK_PERIOD/2) clk = ~clk;

   pdp_line_shifter #(.LANES(LANES), .DEPTH(DEPTH)) i_pdp_line_shifter (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .narrow_mode(narrow_mode),
      .reverse(reverse), .din(din), .line_q(line_q), .line_full(line_full)
   );

   task automatic chk_vec(string req, logic [W-1:0] act, logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s line_q actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_bit(string req, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s line_full actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [LANES-1:0] pat(int seed, int n);
      return LANES'((n * 29 + seed * 53 + n * n) ^ (seed << 2) ^ (n >> 1));
   endfunction

   // Expected contents after n shifts from a cleared register.
   function automatic logic [W-1:0] model(int n, bit nar, bit rev);
      logic [W-1:0] r = '0;
      int s = nar ? LANES / 2 : LANES;
      for (int b = 0; b < W; b++) begin
         int m, idx;
         if (!rev) begin
            m = b / s;
            idx = b % s;
         end else begin
            m = (W - 1 - b) / s;
            idx = s - 1 - ((W - 1 - b) % s);
         end
         if (m < n) r[b] = hist[n-m][idx];
      end
      return r;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      shift_en = 1'b1;
      din = '1;
      @(posedge clk); #1;
      chk_vec("R1", line_q, '0);
      chk_bit("R1", line_full, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      shift_en = 1'b0;
   endtask

   task automatic run_line(bit nar, bit rev, int seed, bit gaps);
      int depth = nar ? 2 * DEPTH : DEPTH;
      string mreq;
      if (!nar) mreq = rev ? "R4" : "R3";
      else      mreq = rev ? "R6,R7" : "R5,R7";
      do_reset();
      narrow_mode = nar;
      reverse = rev;
      for (int n = 1; n <= depth + 1; n++) begin
         if (gaps && (n % 3 == 0)) begin
            @(negedge clk);
            shift_en = 1'b0;
            din = ~pat(seed + 7, n);
            @(posedge clk); #1;
            chk_vec("R2", line_q, model(n - 1, nar, rev));
            chk_bit("R2", line_full, (n - 1) == depth);
         end
         @(negedge clk);
         hist[n] = pat(seed, n);
         din = hist[n];
         shift_en = 1'b1;
         @(posedge clk); #1;
         chk_vec((n == depth) ? {mreq, ",R8"} : mreq, line_q, model(n, nar, rev));
         chk_bit("R9", line_full, n == depth);
      end
      @(negedge clk);
      shift_en = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      for (int mode = 0; mode < 4; mode++) begin
         for (int seed = 1; seed <= 3; seed++) begin
            run_line(mode[1], mode[0], seed, seed == 2);
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule